// File: doc/BRIEF.md
# DMA Request/Acknowledge Handshake Sequencer

This block is a single-channel transfer engine that answers an external, active-low transfer request with an active-low acknowledge. Each accepted request moves exactly one data unit. The block reads the unit from a source address and then writes it to a destination address, acting as master on a simple internal bus with a request/grant handshake. The request pin is asynchronous to the block clock. It passes through a two-stage synchronizer before the sequencer looks at it.

A request is judged by its level. While a unit is in flight, further request activity is ignored. On the first cycle in which the acknowledge is back at its high idle level, the synchronized request is sampled again. If it is still low, the next unit starts without passing through idle. If it is high, the channel goes idle.

A unit counter is loaded when the enable input rises. Once the counter has run down to zero, the channel raises a done flag and refuses requests until it is re-enabled. Only the single / one-unit mode is served, and the mode word must have bits 11 and 9 both clear. In any other mode, requests are not accepted and the acknowledge stays high.

Top module: `dma_handshake_seq`

## Requirements
- R1: While reset is held and right after it, `xfer_ack_n_o` is 1, `bus_req_o` is 0, `bus_we_o` is 0 and `chan_done_o` is 0.
- R2: A request is accepted 3 rising edges after the request pin is sampled low, because of the 2-flop synchronizer plus the idle decision. The source read cycle then starts 3 cycles after acceptance, plus one cycle for each cycle spent waiting for `bus_gnt_i`. Measured from driving the pin low, the read cycle begins after 6 + (grant wait) rising edges.
- R3: Each unit runs as a fixed series of bus cycles:
  - a read cycle with the source address on `bus_addr_o` and `bus_we_o` at 0, with `bus_rdata_i` captured at its end;
  - a destination-address cycle with `bus_we_o` at 0;
  - one cycle with the destination address, `bus_wdata_o` equal to the captured read data, and `bus_we_o` at 1.
- R4: `xfer_ack_n_o` falls on the falling clock edge inside the destination-address cycle, which is after the read data is captured. It rises on the falling edge of the cycle that follows the write-strobe cycle.
- R5: `bus_req_o` rises one cycle before the first read attempt. It stays high without a gap through the write-strobe cycle and drops only after that cycle.
- R6: Once a request is accepted, further pulses on `xfer_req_n_i` during the unit are ignored. Exactly one write occurs per accepted request.
- R7: If the synchronized request is still low in the cycle in which the acknowledge returns high, the next unit is accepted in that cycle. Consecutive source reads are then 7 cycles apart with an immediate grant.
- R8: The unit counter loads `unit_count_i` on a rising `chan_en_i` and drops by one per completed write. When it reaches zero, `chan_done_o` goes to 1 and no request is accepted. A new rising `chan_en_i` with a nonzero count clears `chan_done_o` and resumes service. Loading a count of 0 sets `chan_done_o` at once.
- R9: Requests are accepted only when `chan_mode_i[11]` and `chan_mode_i[9]` are both 0, whatever the other mode bits hold. Otherwise `xfer_req_n_i` is ignored, `xfer_ack_n_o` stays 1 and `bus_req_o` stays 0.
- R10: While `chan_en_i` is 0, no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the acknowledge changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req_n_i | input | 1 | Active-low transfer request, asynchronous |
| xfer_ack_n_o | output | 1 | Active-low transfer acknowledge |
| chan_en_i | input | 1 | Channel enable; its rising edge loads the unit count |
| chan_mode_i | input | MODE_W | Mode word; bits 11 and 9 select the mode |
| unit_count_i | input | CNT_W | Number of units to move after enable |
| src_addr_i | input | ADDR_W | Source address, latched on acceptance |
| dst_addr_i | input | ADDR_W | Destination address, latched on acceptance |
| chan_done_o | output | 1 | Unit count exhausted |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_rdata_i | input | DATA_W | Read data, valid in the read cycle |
| bus_wdata_o | output | DATA_W | Write data |
| bus_we_o | output | 1 | Write strobe |

## Verification
The hardest case to create from the ports is the re-arm decision. Because of the synchronizer lag, the request level seen at the moment the acknowledge releases is two cycles older than the pin. The bench therefore holds the request low across several units and measures the read-to-read spacing. In a separate case, it toggles the pin many times inside a unit and ends those pulses high several cycles before release, so that exactly one write results. Grant delays of 0 to 3 cycles are swept to show that the latency grows by exactly the wait.

// File: rtl/dhs_pkg.sv
package dhs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LAT1, S_LAT2, S_ARB, S_RD, S_WA, S_WD, S_REL
  } dhs_state_e;

  // Mode-word bit positions whose both-zero value selects the served mode
  localparam int unsigned MODE_BURST_BIT = 11;
  localparam int unsigned MODE_MULTI_BIT = 9;

  function automatic logic owns_bus(dhs_state_e s);
    return (s == S_ARB) || (s == S_RD) || (s == S_WA) || (s == S_WD);
  endfunction

  function automatic logic ack_phase(dhs_state_e s);
    return (s == S_WA) || (s == S_WD);
  endfunction

  function automatic logic single_mode(logic burst_bit, logic multi_bit);
    return !burst_bit && !multi_bit;
  endfunction
endpackage

// File: rtl/dhs_req_sync.sv
module dhs_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_async,
  output logic req_seen
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= req_n_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], req_n_async};
      end
    end
  endgenerate

  assign req_seen = !sync_q[STAGES-1];
endmodule

// File: rtl/dhs_xfer_cnt.sv
module dhs_xfer_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] load_val,
  input  logic             unit_done,
  output logic             armed,
  output logic             done
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load_evt;

  function automatic logic [CNT_W-1:0] step_down(logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  assign load_evt = en_i && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      en_q <= en_i;
      if (load_evt) begin
        cnt_q <= load_val;
        done  <= (load_val == '0);
      end else if (unit_done && cnt_q != '0) begin
        cnt_q <= step_down(cnt_q);
        if (step_down(cnt_q) == '0) done <= 1'b1;
      end
    end
  end

  assign armed = en_i && !done && (cnt_q != '0);
endmodule

// File: rtl/dhs_fsm.sv
module dhs_fsm
  import dhs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_seen,
  input  logic              armed,
  input  logic              mode_ok,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic              bus_gnt_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output dhs_state_e        state_o,
  output logic              accept_o,
  output logic              unit_done_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o
);
  dhs_state_e        state_q, state_d;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [DATA_W-1:0] data_q;
  logic              decide;

  // The request is judged only in idle and in the release cycle
  assign decide   = (state_q == S_IDLE) || (state_q == S_REL);
  assign accept_o = decide && req_seen && armed && mode_ok;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (accept_o) state_d = S_LAT1;
      S_LAT1:  state_d = S_LAT2;
      S_LAT2:  state_d = S_ARB;
      S_ARB:   if (bus_gnt_i) state_d = S_RD;
      S_RD:    state_d = S_WA;
      S_WA:    state_d = S_WD;
      S_WD:    state_d = S_REL;
      S_REL:   state_d = accept_o ? S_LAT1 : S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        src_q <= src_i;
        dst_q <= dst_i;
      end
      if (state_q == S_RD) data_q <= bus_rdata_i;
    end
  end

  always_comb begin
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    bus_we_o    = 1'b0;
    case (state_q)
      S_RD: bus_addr_o = src_q;
      S_WA: bus_addr_o = dst_q;
      S_WD: begin
        bus_addr_o  = dst_q;
        bus_wdata_o = data_q;
        bus_we_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assign bus_req_o   = owns_bus(state_q);
  assign unit_done_o = (state_q == S_WD);
  assign state_o     = state_q;
endmodule

// File: rtl/dhs_ack_drv.sv
module dhs_ack_drv
  import dhs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dhs_state_e state_i,
  output logic       ack_n_o
);
  // Falling-edge register: low half a cycle into the destination phases
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ack_n_o <= 1'b1;
    else        ack_n_o <= !ack_phase(state_i);
  end
endmodule

// File: rtl/dma_handshake_seq.sv
module dma_handshake_seq
  import dhs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned MODE_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_req_n_i,
  output logic              xfer_ack_n_o,
  input  logic              chan_en_i,
  input  logic [MODE_W-1:0] chan_mode_i,
  input  logic [CNT_W-1:0]  unit_count_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  output logic              chan_done_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o
);
  logic       req_seen_w;
  logic       armed_w;
  logic       mode_ok_w;
  logic       accept_evt;
  logic       unit_done_evt;
  dhs_state_e state_w;
  logic       unused_mode_bits;

  assign mode_ok_w = single_mode(chan_mode_i[MODE_BURST_BIT], chan_mode_i[MODE_MULTI_BIT]);
  assign unused_mode_bits = ^chan_mode_i;

  dhs_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_n_async (xfer_req_n_i),
    .req_seen    (req_seen_w)
  );

  dhs_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (chan_en_i),
    .load_val  (unit_count_i),
    .unit_done (unit_done_evt),
    .armed     (armed_w),
    .done      (chan_done_o)
  );

  dhs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_seen    (req_seen_w),
    .armed       (armed_w),
    .mode_ok     (mode_ok_w),
    .src_i       (src_addr_i),
    .dst_i       (dst_addr_i),
    .bus_gnt_i   (bus_gnt_i),
    .bus_rdata_i (bus_rdata_i),
    .state_o     (state_w),
    .accept_o    (accept_evt),
    .unit_done_o (unit_done_evt),
    .bus_req_o   (bus_req_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_we_o    (bus_we_o)
  );

  dhs_ack_drv u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (state_w),
    .ack_n_o (xfer_ack_n_o)
  );
endmodule

// File: rtl/dhs_chk.sv
module dhs_chk
  import dhs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ack_n,
  input logic       bus_req,
  input logic       bus_we,
  input logic       bus_gnt,
  input logic       en,
  input logic       done,
  input logic       mode_ok,
  input logic       accept,
  input dhs_state_e state
);
  a_r5_strobe_owns_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_req);
  a_r5_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(bus_we));
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !bus_we);
  a_r3_read_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD) |-> $past(bus_gnt));
  a_r2_req_follows_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(state == S_LAT2));
  a_r2_accept_starts_wait: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == S_LAT1));
  a_r4_ack_low_in_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WA || state == S_WD) |-> !ack_n);
  a_r4_ack_high_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == S_WA || state == S_WD) |-> ack_n);
  a_r6_accept_only_between_units: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (state == S_IDLE || state == S_REL));
  a_r8_done_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !accept);
  a_r9_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |-> !accept);
  a_r10_enable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !accept);
endmodule

bind dma_handshake_seq dhs_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ack_n   (xfer_ack_n_o),
  .bus_req (bus_req_o),
  .bus_we  (bus_we_o),
  .bus_gnt (bus_gnt_i),
  .en      (chan_en_i),
  .done    (chan_done_o),
  .mode_ok (mode_ok_w),
  .accept  (accept_evt),
  .state   (state_w)
);

// File: tb/dma_handshake_seq_bench.sv
`timescale 1ns/1ps
module dma_handshake_seq_bench;
  localparam int AW = 32, DW = 32, CW = 8, MW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_n = 1'b1, en = 1'b0;
  logic [MW-1:0] mode = '0;
  logic [CW-1:0] ucnt = '0;
  logic [AW-1:0] src = 32'h1000_0040, dst = 32'h2000_0080;
  logic          ack_n, done, breq, gnt, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] rdata, wdata;

  int n_chk = 0, n_fail = 0;
  int gdly = 0, wcnt = 0;
  int cyc = 0, n_wr = 0, n_rd = 0, last_rd = 0, gap = 0;
  bit prev_we = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] mem_fn(logic [AW-1:0] a);
    return ~a ^ 32'h5a5a_0f0f;
  endfunction

  assign rdata = mem_fn(addr);
  assign gnt   = breq && (wcnt > gdly);

  always @(negedge clk) wcnt <= breq ? wcnt + 1 : 0;

  dma_handshake_seq u_dma_handshake_seq (
    .clk(clk), .rst_n(rst_n), .xfer_req_n_i(req_n), .xfer_ack_n_o(ack_n),
    .chan_en_i(en), .chan_mode_i(mode), .unit_count_i(ucnt),
    .src_addr_i(src), .dst_addr_i(dst), .chan_done_o(done),
    .bus_req_o(breq), .bus_gnt_i(gnt), .bus_addr_o(addr),
    .bus_rdata_i(rdata), .bus_wdata_o(wdata), .bus_we_o(we)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Bus monitor, sampled 1 ns after each falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (breq && !we && addr == src) begin
        chk(ack_n == 1'b1, "R4 ack high in read cycle", ack_n, 1);
        gap = cyc - last_rd;
        last_rd = cyc;
        n_rd++;
      end
      if (breq && !we && addr == dst)
        chk(ack_n == 1'b0, "R4 ack low in dest addr cycle", ack_n, 0);
      if (we) begin
        n_wr++;
        chk(addr == dst, "R3 write address", addr, dst);
        chk(wdata == mem_fn(src), "R3 write data", wdata, mem_fn(src));
        chk(ack_n == 1'b0, "R4 ack low in strobe cycle", ack_n, 0);
        chk(breq == 1'b1, "R5 bus held in strobe cycle", breq, 1);
      end
      if (prev_we) begin
        chk(ack_n == 1'b1, "R4 ack released after strobe", ack_n, 1);
        chk(we == 1'b0, "R3 single strobe", we, 0);
      end
      prev_we = we;
    end
    cyc++;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enable_with(input int cnt);
    @(negedge clk); en = 1'b0;
    @(negedge clk); ucnt = CW'(cnt); en = 1'b1;
    @(negedge clk);
  endtask

  task automatic quiet_window(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      if (!ack_n || breq) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    int t0, w0;
    cycles(3);
    chk(ack_n == 1'b1 && breq == 1'b0 && we == 1'b0 && done == 1'b0,
        "R1 reset state", {ack_n, breq, we, done}, 4'b1000);
    @(negedge clk); rst_n = 1'b1;
    cycles(2);
    chk(ack_n == 1'b1 && breq == 1'b0 && done == 1'b0, "R1 after reset",
        {ack_n, breq, done}, 3'b100);

    // R10: disabled channel ignores requests
    req_n = 1'b0; w0 = n_wr;
    quiet_window(20, "R10 no activity while disabled");
    req_n = 1'b1; cycles(4);
    chk(n_wr == w0, "R10 no writes while disabled", n_wr, w0);

    // R2 sweep of grant delay with single pulses
    enable_with(20);
    for (int g = 0; g < 4; g++) begin
      gdly = g; src = 32'h1000_0000 + 32'(g * 16); dst = 32'h2000_0100 + 32'(g * 8);
      w0 = n_wr;
      @(negedge clk); req_n = 1'b0; t0 = cyc;
      @(negedge clk); req_n = 1'b1;
      cycles(25);
      chk(last_rd - t0 == 6 + g, "R2 read latency", last_rd - t0, 6 + g);
      chk(n_wr - w0 == 1, "R6 one unit per pulse", n_wr - w0, 1);
      chk(ack_n == 1'b1, "R7 idle after released request", ack_n, 1);
    end

    // R6: extra pulses during a unit are ignored
    gdly = 1; w0 = n_wr; src = 32'h1000_0a00; dst = 32'h2000_0b00;
    @(negedge clk); req_n = 1'b0;
    @(negedge clk); req_n = 1'b1;
    @(negedge clk); req_n = 1'b0;
    @(negedge clk); req_n = 1'b1;
    @(negedge clk); req_n = 1'b0;
    @(negedge clk); req_n = 1'b1;
    cycles(30);
    chk(n_wr - w0 == 1, "R6 pulses inside unit ignored", n_wr - w0, 1);

    // R7 / R8: held request runs back to back until the count is used
    enable_with(3);
    chk(done == 1'b0, "R8 done clear after load", done, 0);
    gdly = 0; w0 = n_wr; src = 32'h1000_0c00; dst = 32'h2000_0d00;
    @(negedge clk); req_n = 1'b0;
    cycles(60);
    chk(n_wr - w0 == 3, "R8 count limits units", n_wr - w0, 3);
    chk(gap == 7, "R7 back-to-back read spacing", gap, 7);
    chk(done == 1'b1, "R8 done after count", done, 1);
    w0 = n_wr;
    quiet_window(20, "R8 no service after done");
    chk(n_wr == w0, "R8 no writes after done", n_wr, w0);
    req_n = 1'b1;

    // R8: re-enable resumes service
    enable_with(2);
    chk(done == 1'b0, "R8 done cleared by re-enable", done, 0);
    w0 = n_wr;
    @(negedge clk); req_n = 1'b0;
    cycles(40); req_n = 1'b1;
    chk(n_wr - w0 == 2, "R8 resumed units", n_wr - w0, 2);
    chk(done == 1'b1, "R8 done again", done, 1);

    // R8: zero count loads as done
    enable_with(0);
    chk(done == 1'b1, "R8 zero load sets done", done, 1);
    w0 = n_wr;
    @(negedge clk); req_n = 1'b0;
    @(negedge clk); req_n = 1'b1;
    cycles(20);
    chk(n_wr == w0, "R8 zero count serves nothing", n_wr, w0);

    // R9: mode selection
    enable_with(10);
    for (int m = 0; m < 2; m++) begin
      mode = (m == 0) ? 16'h0800 : 16'h0200;
      w0 = n_wr; req_n = 1'b0;
      quiet_window(25, "R9 other mode quiet");
      req_n = 1'b1; cycles(4);
      chk(n_wr == w0, "R9 other mode no writes", n_wr, w0);
    end
    mode = 16'hF5FF; w0 = n_wr;
    @(negedge clk); req_n = 1'b0;
    @(negedge clk); req_n = 1'b1;
    cycles(20);
    chk(n_wr - w0 == 1, "R9 unrelated bits ignored", n_wr - w0, 1);

    chk(n_rd == n_wr, "R3 every read paired with a write", n_rd, n_wr);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule